// File: doc/BRIEF.md
# Burst SPI Master

This block is an SPI bus master that moves data in short bursts. Software fills a transmit FIFO with words through a small register port, writes the control register with the start bit set, and the engine shifts out the requested number of words MSB first while it captures the same number of words from the serial input into a receive FIFO. Each burst is limited to the FIFO depth. The selected chip-select pin is driven active only while a burst is in flight, so it works as a per-burst data-valid strobe and not as a select held across a whole transaction.

The serial bit rate comes from a separate clock divider through the `bit_tick` input: every cycle with `bit_tick` high ends one half of an SCLK period. The engine is a six-state machine. IDLE waits for a start. FETCH pops the next transmit word and stays there, with SCLK at its idle level, while the transmit FIFO is empty. HALF_A is the half period with SCLK at its idle level and HALF_B the half period with SCLK inverted. HALF_A goes to HALF_B on a tick (the leading edge). HALF_B goes to HALF_A on a tick while bits remain (the trailing edge), or to STORE after the last bit. STORE pushes the received word and returns to FETCH, or goes to DONE after the final word. DONE raises transfer-complete and returns to IDLE.

Registers sit at word addresses on `bus_addr`: 0 receive data (a read pops), 1 transmit data (a write pushes), 2 control, 3 interrupt enable, 4 status, 5 test. Control fields: bit 0 enable, bit 1 master, bit 2 start, bit 4 clock polarity, bit 5 clock phase, bit 7 select polarity, bits 13:12 select index, bits 24:19 word length minus one, bits 31:25 burst length minus one.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control register reads 0, status reads 0x01, SCLK is 0, all four select pins are high and `irq` is low.
- R2: A word of (control bits 24:19)+1 bits (8, 16, 24 or 32) is sent MSB first from the low bits of the transmit word; the bits above the word length are ignored. The received word is right-aligned, with zeros above the word length.
- R3: SCLK idles at control bit 4. With control bit 5 at 0, both sides sample on the leading edge and data changes on the trailing edge. With bit 5 at 1, data changes on the leading edge and is sampled on the trailing edge.
- R4: During a burst only the pin chosen by control bits 13:12 is active, at the level of control bit 7 (1 means active high), and all pins return to the inactive level at the end of every burst.
- R5: Writing control with bits 0, 1 and 2 set starts a burst of (bits 31:25)+1 words, limited to 16. Without bits 0 and 1 set, no burst starts.
- R6: The start bit reads 1 while a burst runs and 0 after it ends. Control writes during a burst, including a new start, are ignored.
- R7: If the transmit FIFO is empty in the middle of a burst, the engine waits with SCLK idle and the select still active, and it resumes once a word is written.
- R8: Status bits: 0 TX empty, 1 TX at least half full (8 words), 2 TX full, 3 RX not empty, 4 RX at least half full, 5 RX full, 6 RX overflow, 7 transfer complete.
- R9: Transfer complete (status bit 7) sets when a burst ends. Writing 1 to status bit 7 clears it, and writing 1 to status bit 6 clears the overflow flag.
- R10: `irq` is high exactly when a status bit and the same interrupt-enable bit are both 1.
- R11: A received word that arrives when the RX FIFO is full is dropped, sets status bit 6 and leaves the stored words unchanged.
- R12: A write to the test register with bit 22 or bit 23 set empties both FIFOs; a read of an empty RX FIFO returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| bit_tick | input | 1 | Half-SCLK-period enable from the divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select pins |

## Verification
The bench sends words in all four clock modes and all four word lengths, and it decodes MOSI on the sampling edge so that bit order and phase are checked on the wire. A wrong phase or a reversed bit order would corrupt the decoded word. A burst is starved on purpose so that an engine clocking in garbage, or releasing the select early, shows up on SCLK, on the select pins and in the word order. A burst length of 128 words checks the limit at the FIFO depth: without the limit the bit count and the overflow behaviour would be wrong. Further tests check an extra word into a full RX FIFO (lost data or a missing flag), a start written during a burst (it must not retarget the select), the write-one-to-clear flags, the interrupt mask and the FIFO flush.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [2:0] ADDR_RXD   = 3'd0;
    localparam logic [2:0] ADDR_TXD   = 3'd1;
    localparam logic [2:0] ADDR_CTRL  = 3'd2;
    localparam logic [2:0] ADDR_INTEN = 3'd3;
    localparam logic [2:0] ADDR_STAT  = 3'd4;
    localparam logic [2:0] ADDR_TEST  = 3'd5;

    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_MSTR  = 1;
    localparam int unsigned B_START = 2;
    localparam int unsigned B_CPOL  = 4;
    localparam int unsigned B_CPHA  = 5;
    localparam int unsigned B_SPOL  = 7;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_HALF_A,
        ENG_HALF_B,
        ENG_STORE,
        ENG_DONE
    } eng_state_e;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [4:0] wlen_m1;
    } shift_cfg_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    p_flush_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  shift_cfg_t                 cfg,
    input  logic [$clog2(DEPTH)-1:0]   words_m1,
    input  logic                       bit_tick,
    input  logic                       tx_empty,
    input  logic [DATA_W-1:0]          tx_word,
    output logic                       tx_pop,
    output logic                       rx_push,
    output logic [DATA_W-1:0]          rx_word,
    input  logic                       miso,
    output logic                       sclk,
    output logic                       mosi,
    output logic                       sel_active,
    output logic                       busy,
    output logic                       done
);
    localparam int unsigned AW = $clog2(DEPTH);

    eng_state_e        state, nxt;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [4:0]        bit_cnt;
    logic [AW-1:0]     word_cnt;
    logic              first_bit;
    logic [DATA_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:   if (go) nxt = ENG_FETCH;
            ENG_FETCH:  if (!tx_empty) nxt = ENG_HALF_A;
            ENG_HALF_A: if (bit_tick) nxt = ENG_HALF_B;
            ENG_HALF_B: if (bit_tick) nxt = (bit_cnt == '0) ? ENG_STORE : ENG_HALF_A;
            ENG_STORE:  nxt = (word_cnt == words_m1) ? ENG_DONE : ENG_FETCH;
            ENG_DONE:   nxt = ENG_IDLE;
            default:    nxt = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bit_cnt   <= '0;
            word_cnt  <= '0;
            first_bit <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: if (go) word_cnt <= '0;
                ENG_FETCH: if (!tx_empty) begin
                    tx_sh     <= tx_word;
                    rx_sh     <= '0;
                    bit_cnt   <= cfg.wlen_m1;
                    first_bit <= 1'b1;
                end
                ENG_HALF_A: if (bit_tick) begin
                    first_bit <= 1'b0;
                    if (!cfg.cpha)      rx_sh <= {rx_sh[DATA_W-2:0], miso};
                    else if (!first_bit) tx_sh <= tx_sh << 1;
                end
                ENG_HALF_B: if (bit_tick) begin
                    if (!cfg.cpha) tx_sh <= tx_sh << 1;
                    else           rx_sh <= {rx_sh[DATA_W-2:0], miso};
                    if (bit_cnt != '0) bit_cnt <= bit_cnt - 1'b1;
                end
                ENG_STORE: if (word_cnt != words_m1) word_cnt <= word_cnt + 1'b1;
                default: ;
            endcase
        end
    end

    assign mask = {DATA_W{1'b1}} >> (5'd31 - cfg.wlen_m1);

    always_comb begin
        sclk       = cfg.cpol ^ (state == ENG_HALF_B);
        mosi       = tx_sh[cfg.wlen_m1];
        tx_pop     = (state == ENG_FETCH) && !tx_empty;
        rx_push    = (state == ENG_STORE);
        rx_word    = rx_sh & mask;
        busy       = (state != ENG_IDLE);
        done       = (state == ENG_DONE);
        sel_active = (state == ENG_FETCH) || (state == ENG_HALF_A) ||
                     (state == ENG_HALF_B) || (state == ENG_STORE);
    end

    p_word_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> word_cnt <= words_m1);
    p_stall_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_FETCH && tx_empty) |=> state == ENG_FETCH);
    p_push_after_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(state) == ENG_HALF_B);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        bit_tick,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs
);
    localparam int unsigned AW     = $clog2(FIFO_DEPTH);
    localparam int unsigned NUM_CS = 4;
    localparam logic [AW:0] HALF   = (AW+1)'(FIFO_DEPTH / 2);

    logic [31:0]       ctrl_q;
    logic [7:0]        inten_q;
    logic              tc_q, ro_q;
    logic              wr_any, rd_any, go, flush;
    logic              busy, done, sel_active;
    logic              tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_word, rx_word, rx_head;
    logic [AW:0]       tx_cnt, rx_cnt;
    logic [7:0]        status;
    logic [5:0]        wl_field;
    logic [6:0]        bl_field;
    shift_cfg_t        cfg;
    logic [AW-1:0]     words_m1;

    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && !bus_wr;
    assign go     = wr_any && (bus_addr == ADDR_CTRL) && !busy &&
                    bus_wdata[B_EN] && bus_wdata[B_MSTR] && bus_wdata[B_START];
    assign flush  = wr_any && (bus_addr == ADDR_TEST) && (bus_wdata[22] || bus_wdata[23]);

    assign wl_field    = ctrl_q[24:19];
    assign bl_field    = ctrl_q[31:25];
    assign cfg.cpol    = ctrl_q[B_CPOL];
    assign cfg.cpha    = ctrl_q[B_CPHA];
    assign cfg.wlen_m1 = (wl_field > 6'd31) ? 5'd31 : wl_field[4:0];
    assign words_m1    = (bl_field > 7'(FIFO_DEPTH - 1)) ? AW'(FIFO_DEPTH - 1) : bl_field[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            inten_q <= '0;
            tc_q    <= 1'b0;
            ro_q    <= 1'b0;
        end else begin
            if (wr_any && bus_addr == ADDR_CTRL && !busy)
                ctrl_q <= bus_wdata & ~(32'd1 << B_START);
            if (wr_any && bus_addr == ADDR_INTEN)
                inten_q <= bus_wdata[7:0];
            if (done)
                tc_q <= 1'b1;
            else if (wr_any && bus_addr == ADDR_STAT && bus_wdata[7])
                tc_q <= 1'b0;
            if (rx_push && rx_full)
                ro_q <= 1'b1;
            else if (wr_any && bus_addr == ADDR_STAT && bus_wdata[6])
                ro_q <= 1'b0;
        end
    end

    spi_burst_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr_any && bus_addr == ADDR_TXD), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_word), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));

    spi_burst_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .wdata(rx_word),
        .pop(rd_any && bus_addr == ADDR_RXD), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty));

    spi_burst_engine #(.DEPTH(FIFO_DEPTH)) i_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg), .words_m1(words_m1),
        .bit_tick(bit_tick), .tx_empty(tx_empty), .tx_word(tx_word),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .miso(miso),
        .sclk(sclk), .mosi(mosi), .sel_active(sel_active), .busy(busy), .done(done));

    assign status = {tc_q, ro_q, rx_full, rx_cnt >= HALF, !rx_empty,
                     tx_full, tx_cnt >= HALF, tx_empty};
    assign irq    = |(status & inten_q);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs[g] = (sel_active && ctrl_q[13:12] == 2'(g)) ? ctrl_q[B_SPOL] : !ctrl_q[B_SPOL];
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_RXD:   bus_rdata = rx_empty ? '0 : rx_head;
            ADDR_CTRL:  bus_rdata = ctrl_q | (32'(busy) << B_START);
            ADDR_INTEN: bus_rdata = {24'd0, inten_q};
            ADDR_STAT:  bus_rdata = {24'd0, status};
            default:    bus_rdata = '0;
        endcase
    end

    p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs ^ {NUM_CS{!ctrl_q[B_SPOL]}}));
    p_ctrl_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl_q));
    p_tc_on_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tc_q);
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == ctrl_q[B_CPOL]);
endmodule

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, sclk, mosi, miso;
    logic        bit_tick = 1'b1;
    logic [3:0]  cs;

    always #10 clk = ~clk;
    assign miso = mosi;

    spi_burst_master i_spi_burst_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .bit_tick(bit_tick), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs(cs));

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [5:0]  wlm1;
        logic [1:0]  csi;
        logic        pol;
        logic [31:0] word;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 6'd7,  2'd0, 1'b0, 32'h0000_00A5},
        '{1'b1, 1'b0, 6'd15, 2'd1, 1'b0, 32'h0000_1234},
        '{1'b0, 1'b1, 6'd23, 2'd2, 1'b1, 32'h00AB_CDEF},
        '{1'b1, 1'b1, 6'd31, 2'd3, 1'b0, 32'hDEAD_BEEF},
        '{1'b0, 1'b0, 6'd31, 2'd1, 1'b1, 32'h8000_0001},
        '{1'b1, 1'b1, 6'd7,  2'd0, 1'b1, 32'hFFFF_FF3C}
    };

    int errs = 0, checks = 0;
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, mon_en = 1'b0;
    logic        prev_sclk = 1'b0;
    logic [31:0] mon = '0;
    int          mon_cnt = 0;

    // Wire-side decoder: captures MOSI on the sampling edge of the mode.
    always @(negedge clk) begin
        if (mon_en && sclk != prev_sclk) begin
            if ((sclk != cur_cpol) != cur_cpha) begin
                mon     <= {mon[30:0], mosi};
                mon_cnt <= mon_cnt + 1;
            end
        end
        prev_sclk <= sclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_tc(input string req);
        logic [31:0] s;
        s = '0;
        for (int n = 0; n < 3000; n++) begin
            brd(3'd4, s);
            if (s[7]) break;
        end
        chk(req, {31'd0, s[7]}, 32'd1);
    endtask

    function automatic logic [31:0] mkctrl(input logic cpol, input logic cpha,
            input logic [5:0] wlm1, input logic [1:0] csi, input logic pol,
            input logic [6:0] blm1, input logic start);
        return 32'h3 | (32'(start) << 2) | (32'(cpol) << 4) | (32'(cpha) << 5) |
               (32'(pol) << 7) | (32'(csi) << 12) | (32'(wlm1) << 19) | (32'(blm1) << 25);
    endfunction

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d, m;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        brd(3'd2, d); chk("R1 ctrl", d, 32'd0);
        brd(3'd4, d); chk("R1 R8 status", d, 32'h01);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 cs", {28'd0, cs}, 32'hF);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // Table walk: modes, lengths, selects (R2 R3 R4 R6 R9)
        foreach (VEC[i]) begin
            cur_cpol = VEC[i].cpol; cur_cpha = VEC[i].cpha;
            bwr(3'd2, mkctrl(VEC[i].cpol, VEC[i].cpha, VEC[i].wlm1, VEC[i].csi, VEC[i].pol, 7'd0, 1'b0));
            bwr(3'd1, VEC[i].word);
            chk("R3 idle sclk", {31'd0, sclk}, {31'd0, VEC[i].cpol});
            mon_en = 1'b1; c0 = mon_cnt;
            bwr(3'd2, mkctrl(VEC[i].cpol, VEC[i].cpha, VEC[i].wlm1, VEC[i].csi, VEC[i].pol, 7'd0, 1'b1));
            d = VEC[i].pol ? (32'd1 << VEC[i].csi) : (~(32'd1 << VEC[i].csi) & 32'hF);
            chk("R4 active select", {28'd0, cs}, d);
            wait_tc("R9 tc set");
            mon_en = 1'b0;
            chk("R4 select released", {28'd0, cs}, VEC[i].pol ? 32'h0 : 32'hF);
            brd(3'd2, d); chk("R6 start cleared", {31'd0, d[2]}, 32'd0);
            m = (VEC[i].wlm1 == 6'd31) ? 32'hFFFF_FFFF : ((32'd1 << (VEC[i].wlm1 + 1)) - 1);
            brd(3'd0, d); chk("R2 rx word", d, VEC[i].word & m);
            chk("R2 R3 wire word", mon & m, VEC[i].word & m);
            chk("R2 bit count", 32'(mon_cnt - c0), 32'(VEC[i].wlm1) + 1);
            bwr(3'd4, 32'h80);
            brd(3'd4, d); chk("R9 tc cleared", {31'd0, d[7]}, 32'd0);
        end

        // R7 stall on empty TX, R6 start ignored while busy
        cur_cpol = 1'b0; cur_cpha = 1'b0;
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd2, 1'b0));
        bwr(3'd1, 32'h11); bwr(3'd1, 32'h22);
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd2, 1'b1));
        repeat (60) @(negedge clk);
        brd(3'd4, d); chk("R7 no tc while starved", {31'd0, d[7]}, 32'd0);
        chk("R7 sclk idle in stall", {31'd0, sclk}, 32'd0);
        chk("R7 select held in stall", {28'd0, cs}, 32'hE);
        brd(3'd2, d); chk("R6 start reads busy", {31'd0, d[2]}, 32'd1);
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd3, 1'b0, 7'd2, 1'b1));
        chk("R6 restart ignored", {28'd0, cs}, 32'hE);
        brd(3'd2, d); chk("R6 ctrl unchanged", {30'd0, d[13:12]}, 32'd0);
        bwr(3'd1, 32'h33);
        wait_tc("R7 resumes");
        brd(3'd0, d); chk("R5 word 0", d, 32'h11);
        brd(3'd0, d); chk("R5 word 1", d, 32'h22);
        brd(3'd0, d); chk("R5 word 2", d, 32'h33);
        brd(3'd4, d); chk("R8 status after", d, 32'h81);
        bwr(3'd4, 32'h80);

        // R5 burst limited to FIFO depth; R8 flags; R11 overflow
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd127, 1'b0));
        for (int k = 0; k < 16; k++) bwr(3'd1, 32'h40 + 32'(k));
        brd(3'd4, d); chk("R8 tx full/half", d, 32'h06);
        mon_en = 1'b1; c0 = mon_cnt;
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd127, 1'b1));
        wait_tc("R5 clamped burst ends");
        mon_en = 1'b0;
        chk("R5 clamp 16 words", 32'(mon_cnt - c0), 32'd128);
        brd(3'd4, d); chk("R8 rx full", d, 32'hB9);
        bwr(3'd4, 32'h80);
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd0, 1'b0));
        bwr(3'd1, 32'h99);
        bwr(3'd2, mkctrl(1'b0, 1'b0, 6'd7, 2'd0, 1'b0, 7'd0, 1'b1));
        wait_tc("R11 extra burst");
        brd(3'd4, d); chk("R11 overflow flag", d, 32'hF9);
        brd(3'd0, d); chk("R11 head kept", d, 32'h40);

        // R10 interrupt mask
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        bwr(3'd3, 32'h80); chk("R10 irq tc", {31'd0, irq}, 32'd1);
        bwr(3'd3, 32'h40); chk("R10 irq ovf", {31'd0, irq}, 32'd1);
        bwr(3'd4, 32'hC0); chk("R10 irq after clear", {31'd0, irq}, 32'd0);
        brd(3'd4, d); chk("R9 both flags cleared", d, 32'h19);

        // R12 FIFO flush
        bwr(3'd1, 32'h1); bwr(3'd1, 32'h2);
        bwr(3'd5, 32'd1 << 22);
        brd(3'd4, d); chk("R12 both emptied", d, 32'h01);
        brd(3'd0, d); chk("R12 empty read", d, 32'd0);

        // R5 no start without enable and master
        bwr(3'd2, 32'h4);
        repeat (10) @(negedge clk);
        chk("R5 no burst when disabled", {28'd0, cs}, 32'hF);
        brd(3'd4, d); chk("R5 no tc when disabled", d, 32'h01);

        report();
        $finish;
    end
endmodule